// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a virtual address into a physical address by reading a two-level page table from memory. The virtual address is cut into three fields: a top-level index (upper bits), a second-level index (middle bits) and a page offset (low bits). The top-level table starts at a page frame supplied on a configuration input. The walker reads one 32-bit entry from that table. If the entry is marked present, it reads a second entry from the table frame that the first entry names. Otherwise it stops at once with a fault.

A present leaf entry gives the physical page frame and a two-bit rights code. The page offset is carried across unchanged into the physical address. An absent leaf is reported as a fault. Every fault result states which level was missing, so a missing second-level table can be told apart from a page that is not resident.

Memory is reached through a valid/ready request channel and a response-valid return channel. A requester hands in one address at a time and acknowledges each result. Any larger translation structure sits outside this block.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, while `mem_req_valid` and `res_valid` are 0.
- R2: A request is accepted only when `req_ready` is high, and `req_ready` is high only in the idle state. A `req_valid` or `req_vaddr` presented while a walk is in progress has no effect on the walk or on its result.
- R3: The first memory read goes to address `cfg_root_frame * 2^OFF_W + top_index * 4`. Here `top_index` is the upper IDX_W bits of the virtual address captured at acceptance.
- R4: A second memory read is issued only when bit 0 (present) of the top-level entry is 1. Its address is `entry[31:OFF_W] * 2^OFF_W + mid_index * 4`, where `mid_index` is the next IDX_W bits of the virtual address.
- R5: A top-level entry with bit 0 clear ends the walk after exactly one memory read, with `res_fault`=1 and `res_fault_level`=0.
- R6: A second-level entry with bit 0 clear ends the walk with `res_fault`=1 and `res_fault_level`=1.
- R7: A second-level entry with bit 0 set ends the walk with `res_fault`=0. It also gives `res_paddr = {entry[31:OFF_W], page offset}` and `res_rights` = entry bits 2:1, where 00 is read-only, 01 is read/write and 10 is executable.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` does not change.
- R9: While `res_valid` is high and `res_ack` is low, all result outputs hold their values. The cycle after `res_ack` is seen, the walker is idle again.
- R10: Entry bits OFF_W-1:3 never affect the result, and neither do bits 2:1 of a top-level entry. The low OFF_W bits of `res_paddr` always equal the page offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_root_frame | input | 32-OFF_W | Page frame of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 2*IDX_W+OFF_W | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read |
| res_valid | output | 1 | Result available |
| res_ack | input | 1 | Requester takes the result |
| res_fault | output | 1 | Translation failed |
| res_fault_level | output | 1 | 0: top-level entry absent, 1: leaf absent |
| res_paddr | output | 32 | Physical address |
| res_rights | output | 2 | Access rights from the leaf |

## Verification
The bench builds the walker with IDX_W=3 and OFF_W=8, which gives a 14-bit virtual address, eight-entry tables and padding bits between the index and the entry alignment. At that size every pair of top and second index can be walked under two different root frames and two present/absent patterns. This drives every fault level, every rights code and a range of memory stall and latency lengths, with each entry address and physical address derived arithmetically.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ_L1 = 3'd1,
    ST_WAIT_L1 = 3'd2,
    ST_READ_L2 = 3'd3,
    ST_WAIT_L2 = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6
  } walk_state_e;

  localparam int RIGHTS_W = 2;
  typedef logic [RIGHTS_W-1:0] rights_t;

  localparam int PRESENT_BIT = 0;
  localparam int RIGHTS_LSB  = 1;

endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        entry_present,
  input  logic        res_ack,
  output walk_state_e state,
  output logic        req_ready,
  output logic        mem_req_valid,
  output logic        use_l2,
  output logic        res_valid,
  output logic        accept,
  output logic        l1_take,
  output logic        l2_take
);

  walk_state_e state_q;
  walk_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_READ_L1;
      ST_READ_L1: if (mem_req_ready) state_d = ST_WAIT_L1;
      ST_WAIT_L1: if (mem_rsp_valid) state_d = entry_present ? ST_READ_L2 : ST_FAULT;
      ST_READ_L2: if (mem_req_ready) state_d = ST_WAIT_L2;
      ST_WAIT_L2: if (mem_rsp_valid) state_d = entry_present ? ST_DONE : ST_FAULT;
      ST_DONE:    if (res_ack) state_d = ST_IDLE;
      ST_FAULT:   if (res_ack) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state         = state_q;
  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_READ_L1) || (state_q == ST_READ_L2);
  assign use_l2        = (state_q == ST_READ_L2);
  assign res_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign accept        = req_ready && req_valid;
  assign l1_take       = (state_q == ST_WAIT_L1) && mem_rsp_valid;
  assign l2_take       = (state_q == ST_WAIT_L2) && mem_rsp_valid;

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic                    use_l2,
  input  logic [ADDR_W-OFF_W-1:0] root_frame,
  input  logic [ADDR_W-OFF_W-1:0] table_frame,
  input  logic [IDX_W-1:0]        idx_top,
  input  logic [IDX_W-1:0]        idx_mid,
  output logic [ADDR_W-1:0]       entry_addr
);

  localparam int PAD_W = OFF_W - IDX_W - 2;

  logic [ADDR_W-OFF_W-1:0] sel_frame;
  logic [IDX_W-1:0]        sel_idx;

  assign sel_frame = use_l2 ? table_frame : root_frame;
  assign sel_idx   = use_l2 ? idx_mid : idx_top;

  generate
    if (PAD_W > 0) begin : g_pad
      assign entry_addr = {sel_frame, {PAD_W{1'b0}}, sel_idx, 2'b00};
    end else begin : g_nopad
      assign entry_addr = {sel_frame, sel_idx, 2'b00};
    end
  endgenerate

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]       entry,
  output logic                    present,
  output rights_t                 rights,
  output logic [ADDR_W-OFF_W-1:0] frame
);

  assign present = entry[PRESENT_BIT];
  assign rights  = entry[RIGHTS_LSB +: RIGHTS_W];
  assign frame   = entry[ADDR_W-1:OFF_W];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [32-OFF_W-1:0]        cfg_root_frame,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]   req_vaddr,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [31:0]                mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [31:0]                mem_rsp_data,
  output logic                       res_valid,
  input  logic                       res_ack,
  output logic                       res_fault,
  output logic                       res_fault_level,
  output logic [31:0]                res_paddr,
  output logic [1:0]                 res_rights
);

  localparam int ADDR_W  = 32;
  localparam int VA_W    = 2 * IDX_W + OFF_W;
  localparam int FRAME_W = ADDR_W - OFF_W;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  walk_state_e state;
  logic        use_l2;
  logic        accept;
  logic        l1_take;
  logic        l2_take;
  logic        entry_present;
  rights_t     entry_rights;
  logic [FRAME_W-1:0] entry_frame;

  logic [VA_W-1:0]    vaddr_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] table_q;
  logic [FRAME_W-1:0] res_frame_q;
  rights_t            res_rights_q;
  logic               res_fault_q;
  logic               res_level_q;

  pt_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_present (entry_present),
    .res_ack       (res_ack),
    .state         (state),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .use_l2        (use_l2),
    .res_valid     (res_valid),
    .accept        (accept),
    .l1_take       (l1_take),
    .l2_take       (l2_take)
  );

  pt_entry_decode #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_dec (
    .entry   (mem_rsp_data),
    .present (entry_present),
    .rights  (entry_rights),
    .frame   (entry_frame)
  );

  pt_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_addr (
    .use_l2      (use_l2),
    .root_frame  (root_q),
    .table_frame (table_q),
    .idx_top     (vaddr_q[VA_W-1 -: IDX_W]),
    .idx_mid     (vaddr_q[OFF_W +: IDX_W]),
    .entry_addr  (mem_req_addr)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vaddr_q <= '0;
      root_q  <= '0;
    end else if (accept) begin
      vaddr_q <= req_vaddr;
      root_q  <= cfg_root_frame;
    end
  end

  // second-level table frame
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                  table_q <= '0;
    else if (l1_take && entry_present) table_q <= entry_frame;
  end

  // leaf result
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_frame_q  <= '0;
      res_rights_q <= '0;
    end else if (l2_take && entry_present) begin
      res_frame_q  <= entry_frame;
      res_rights_q <= entry_rights;
    end
  end

  // fault flag and level
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_fault_q <= 1'b0;
      res_level_q <= 1'b0;
    end else if (l1_take || l2_take) begin
      res_fault_q <= !entry_present;
      res_level_q <= l2_take;
    end
  end

  assign res_fault       = res_fault_q;
  assign res_fault_level = res_level_q;
  assign res_paddr       = {res_frame_q, vaddr_q[OFF_W-1:0]};
  assign res_rights      = res_rights_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [32-OFF_W-1:0]      cfg_root_frame,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [2*IDX_W+OFF_W-1:0] req_vaddr,
  input logic                     mem_req_valid,
  input logic                     mem_req_ready,
  input logic [31:0]              mem_req_addr,
  input logic                     res_valid,
  input logic                     res_ack,
  input logic                     res_fault,
  input logic                     res_fault_level,
  input logic [31:0]              res_paddr,
  input logic [1:0]               res_rights
);

  localparam int VA_W = 2 * IDX_W + OFF_W;

  logic [31:0] exp_l1_addr;
  logic [1:0]  reads_q;

  assign exp_l1_addr = (32'(cfg_root_frame) << OFF_W)
                     + (32'(req_vaddr[VA_W-1 -: IDX_W]) << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        reads_q <= 2'd0;
    else if (req_valid && req_ready)                   reads_q <= 2'd0;
    else if (mem_req_valid && mem_req_ready && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
  end

  assert_idle_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  assert_first_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_valid && mem_req_addr == $past(exp_l1_addr)));

  assert_leaf_two_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (reads_q == 2'd2));

  assert_early_fault_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault && !res_fault_level) |-> (reads_q == 2'd1));

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_fault) && $stable(res_fault_level)
                                 && $stable(res_paddr) && $stable(res_rights)));

  assert_ack_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |=> req_ready);

endmodule

bind pt_walker pt_walker_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .cfg_root_frame  (cfg_root_frame),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_vaddr       (req_vaddr),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .res_valid       (res_valid),
  .res_ack         (res_ack),
  .res_fault       (res_fault),
  .res_fault_level (res_fault_level),
  .res_paddr       (res_paddr),
  .res_rights      (res_rights)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  localparam int IDX_W = 3;
  localparam int OFF_W = 8;
  localparam int VA_W  = 2 * IDX_W + OFF_W;
  localparam int FW    = 32 - OFF_W;
  localparam int NIDX  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [FW-1:0]     cfg_root_frame;
  logic              req_valid;
  logic              req_ready;
  logic [VA_W-1:0]   req_vaddr;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [31:0]       mem_req_addr;
  logic              mem_rsp_valid;
  logic [31:0]       mem_rsp_data;
  logic              res_valid;
  logic              res_ack;
  logic              res_fault;
  logic              res_fault_level;
  logic [31:0]       res_paddr;
  logic [1:0]        res_rights;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pt_walker #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_root_frame(cfg_root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ack(res_ack),
    .res_fault(res_fault), .res_fault_level(res_fault_level),
    .res_paddr(res_paddr), .res_rights(res_rights)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] root_of(input int s);
    return FW'(32'h40 + s);
  endfunction

  function automatic logic [FW-1:0] l2_frame_of(input int s, input int i);
    return FW'(32'h100 + s * 16 + i);
  endfunction

  function automatic logic [31:0] pte_top(input int s, input int i);
    logic v;
    v = ((i + s) % 3) != 0;
    return {l2_frame_of(s, i), 5'(i * 3 + s), 2'(i), v};
  endfunction

  function automatic logic [31:0] pte_leaf(input int s, input int i, input int j);
    logic v;
    v = ((i * 8 + j + s) % 5) != 0;
    return {FW'(32'hA000 + s * 256 + i * 16 + j), 5'(i ^ j ^ s), 2'((i + j + s) % 3), v};
  endfunction

  // one memory read: check the request, stall it, then return data
  task automatic mem_phase(input logic [31:0] exp_addr, input int stall, input int dly,
                           input logic [31:0] data, input string tag);
    logic [31:0] a0;
    check(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, tag, mem_req_addr, exp_addr);
    check(req_ready === 1'b0, "R2 busy walker not ready", 32'(req_ready), 32'd0);
    a0 = mem_req_addr;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(mem_req_valid === 1'b1 && mem_req_addr === a0, "R8 request held", mem_req_addr, a0);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int k = 0; k < dly; k++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
  endtask

  task automatic walk(input int s, input int i, input int j);
    logic [VA_W-1:0] va;
    logic [31:0] e1, e2, a1, a2, exp_pa, p0;
    logic [7:0]  off;
    off = 8'(i * 37 + j * 11 + s * 5);
    va  = {3'(i), 3'(j), off};
    e1  = pte_top(s, i);
    e2  = pte_leaf(s, i, j);
    a1  = 32'(root_of(s)) * 256 + 32'(i) * 4;
    a2  = (e1 & 32'hFFFF_FF00) + 32'(j) * 4;
    cfg_root_frame = root_of(s);
    req_vaddr = va;
    req_valid = 1'b1;
    check(req_ready === 1'b1, "R2 idle walker ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_vaddr = ~va;              // R2: changed request while busy must be ignored
    cfg_root_frame = ~root_of(s);
    mem_phase(a1, (i + j) % 3, (i * j) % 3, e1, "R3 top entry address");
    if (!e1[0]) begin
      check(res_valid === 1'b1 && res_fault === 1'b1 && res_fault_level === 1'b0
            && mem_req_valid === 1'b0, "R5 top-level fault after one read",
            {res_valid, res_fault, res_fault_level, mem_req_valid}, 32'b1100);
    end else begin
      mem_phase(a2, (i + 2 * j) % 4, (j + s) % 2, e2, "R4 leaf entry address");
      if (!e2[0]) begin
        check(res_valid === 1'b1 && res_fault === 1'b1 && res_fault_level === 1'b1,
              "R6 leaf fault", {res_valid, res_fault, res_fault_level}, 32'b111);
      end else begin
        exp_pa = {e2[31:8], off};
        check(res_valid === 1'b1 && res_fault === 1'b0, "R7 leaf success",
              {res_valid, res_fault}, 32'b10);
        check(res_paddr === exp_pa, "R7 physical address", res_paddr, exp_pa);
        check(res_rights === e2[2:1], "R7 rights", 32'(res_rights), 32'(e2[2:1]));
        check(res_paddr[7:0] === off, "R10 offset untouched by entry low bits",
              32'(res_paddr[7:0]), 32'(off));
      end
    end
    req_valid = 1'b0;
    p0 = res_paddr;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(res_valid === 1'b1 && res_paddr === p0, "R9 result held", res_paddr, p0);
    end
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
    check(req_ready === 1'b1 && res_valid === 1'b0, "R9 idle after ack",
          {req_ready, res_valid}, 32'b10);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_root_frame = '0;
    req_valid = 1'b0;
    req_vaddr = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = 32'h0;
    res_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && mem_req_valid === 1'b0 && res_valid === 1'b0,
          "R1 reset state", {req_ready, mem_req_valid, res_valid}, 32'b100);
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < NIDX; i++)
        for (int j = 0; j < NIDX; j++)
          walk(s, i, j);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule